// File: doc/BRIEF.md
# SIMD Lane Flag Condition Unit

This block holds two condition bits, called A and B, for every lane of a SIMD shader core, and turns the 7-bit condition field of each issued instruction into per-lane write enables for the two parallel pipes (add and mul). The field is prefix coded. Depending on its upper bits, it carries one of three kinds of setting for each pipe: a flag push that shifts a fresh test result into the flags, a flag update that folds a test result into A, or an execute predicate that masks the pipe's writes lane by lane.

The lane tests (zero, negative, carry) come from the pipe that owns the push or update in the current instruction. Predicates read the flags as they were before the instruction. Any new flag values are committed on the clock edge that ends the valid cycle. An illegal field value raises an error. It also suppresses all writes and leaves the flags as they were.

Top module: `lane_flag_cond`

## Requirements
- R1: While reset is held, and on its release, flag_a and flag_b are all zero and cond_err is low.
- R2: With valid low, add_we, mul_we and cond_err are zero and both flag vectors keep their values.
- R3: The field value 0000000 sets both write-enable masks to all ones and changes no flag.
- R4: Prefix 000 gives the add pipe a push when bits 3:2 are zero, and otherwise a flag update with code bits 3:0. Prefix 001 does the same for the mul pipe. Neither form predicates any pipe.
- R5: Prefix 010 predicates the add pipe with bits 3:2 and gives the mul pipe a push with bits 1:0. Prefix 011 predicates the mul pipe with bits 3:2 and gives the add pipe a push with bits 1:0. In both, a push code of 0 means no push.
- R6: With bit 6 set, bits 5:4 predicate the mul pipe. If bits 3:2 are zero, bits 1:0 predicate the add pipe. Otherwise, bits 3:0 are an add-pipe flag update code.
- R7: Push code 1, 2 or 3 selects the zero, negative or carry test. In every lane B takes the old A, and A takes the selected test.
- R8: Update code u (1..12) uses k=u-1. The test is k/4 (0 zero, 1 negative, 2 carry). The form is k%4: 0 gives A&t, 1 gives A&~t, 2 gives ~(A|~t), 3 gives ~(A|t). B is unchanged.
- R9: Predicate code 0 enables lanes where A is set, 1 where B is set, 2 where A is clear, and 3 where B is clear. The flags used are those before the instruction.
- R10: A pipe with no predicate in the current field has an all-ones write-enable mask.
- R11: The field value 0010000 and update codes 13 to 15 raise cond_err. They zero both masks and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | An instruction is issued this cycle |
| cond | input | 7 | Combined condition field |
| add_z | input | LANES | Add-pipe zero result per lane |
| add_n | input | LANES | Add-pipe negative result per lane |
| add_c | input | LANES | Add-pipe carry result per lane |
| mul_z | input | LANES | Mul-pipe zero result per lane |
| mul_n | input | LANES | Mul-pipe negative result per lane |
| mul_c | input | LANES | Mul-pipe carry result per lane |
| add_we | output | LANES | Add-pipe per-lane write enable |
| mul_we | output | LANES | Mul-pipe per-lane write enable |
| flag_a | output | LANES | Current A flag per lane |
| flag_b | output | LANES | Current B flag per lane |
| cond_err | output | 1 | Illegal condition field this cycle |

## Verification
The assertions assume that cond and the lane result buses are stable and known whenever valid is high, and that the result buses carry the tests of the current instruction. The bench drives every input at the falling edge and holds it through the following rising edge. It sweeps all 128 field values several times, each with fresh pseudo-random lane results. Through that sequence the flags themselves wander across many lane patterns, and the predicates are judged against those patterns.

// File: rtl/lane_flag_cond.sv
module lane_flag_cond #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [6:0]       cond,
  input  logic [LANES-1:0] add_z,
  input  logic [LANES-1:0] add_n,
  input  logic [LANES-1:0] add_c,
  input  logic [LANES-1:0] mul_z,
  input  logic [LANES-1:0] mul_n,
  input  logic [LANES-1:0] mul_c,
  output logic [LANES-1:0] add_we,
  output logic [LANES-1:0] mul_we,
  output logic [LANES-1:0] flag_a,
  output logic [LANES-1:0] flag_b,
  output logic             cond_err
);

  logic [1:0] add_push, mul_push, add_pred, mul_pred, push;
  logic [3:0] add_upd, mul_upd, upd, k;
  logic       add_pe, mul_pe, bad, mul_mod;
  logic [LANES-1:0] tz, tn, tc, t, nxt_a, nxt_b;

  function automatic logic [LANES-1:0] pick(input logic [1:0] p,
                                            input logic [LANES-1:0] a,
                                            input logic [LANES-1:0] b);
    case (p)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return ~a;
      default: return ~b;
    endcase
  endfunction

  always_comb begin
    add_push = '0; mul_push = '0; add_upd = '0; mul_upd = '0;
    add_pred = '0; mul_pred = '0; add_pe = 1'b0; mul_pe = 1'b0; bad = 1'b0;
    if (cond == 7'd0) begin
    end else if (cond[6:4] == 3'b000) begin
      if (cond[3:2] == 2'd0) add_push = cond[1:0];
      else begin add_upd = cond[3:0]; bad = cond[3:0] > 4'd12; end
    end else if (cond[6:4] == 3'b001) begin
      if (cond[3:0] == 4'd0) bad = 1'b1;
      else if (cond[3:2] == 2'd0) mul_push = cond[1:0];
      else begin mul_upd = cond[3:0]; bad = cond[3:0] > 4'd12; end
    end else if (cond[6:4] == 3'b010) begin
      add_pe = 1'b1; add_pred = cond[3:2]; mul_push = cond[1:0];
    end else if (cond[6:4] == 3'b011) begin
      mul_pe = 1'b1; mul_pred = cond[3:2]; add_push = cond[1:0];
    end else begin
      mul_pe = 1'b1; mul_pred = cond[5:4];
      if (cond[3:2] == 2'd0) begin add_pe = 1'b1; add_pred = cond[1:0]; end
      else begin add_upd = cond[3:0]; bad = cond[3:0] > 4'd12; end
    end
  end

  assign mul_mod = (mul_push != 2'd0) || (mul_upd != 4'd0);
  assign tz      = mul_mod ? mul_z : add_z;
  assign tn      = mul_mod ? mul_n : add_n;
  assign tc      = mul_mod ? mul_c : add_c;
  assign push    = add_push | mul_push;
  assign upd     = add_upd | mul_upd;
  assign k       = upd - 4'd1;

  always_comb begin
    nxt_a = flag_a;
    nxt_b = flag_b;
    t     = k[3] ? tc : (k[2] ? tn : tz);
    if (push != 2'd0) begin
      nxt_b = flag_a;
      nxt_a = (push == 2'd1) ? tz : (push == 2'd2) ? tn : tc;
    end else if (upd != 4'd0) begin
      case (k[1:0])
        2'd0:    nxt_a = flag_a & t;
        2'd1:    nxt_a = flag_a & ~t;
        2'd2:    nxt_a = ~(flag_a | ~t);
        default: nxt_a = ~(flag_a | t);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= '0;
      flag_b <= '0;
    end else if (valid && !bad) begin
      flag_a <= nxt_a;
      flag_b <= nxt_b;
    end
  end

  assign cond_err = valid && bad;
  assign add_we   = (valid && !bad) ? (add_pe ? pick(add_pred, flag_a, flag_b) : '1) : '0;
  assign mul_we   = (valid && !bad) ? (mul_pe ? pick(mul_pred, flag_a, flag_b) : '1) : '0;

endmodule

module lane_flag_cond_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic [6:0]       cond,
  input logic [LANES-1:0] add_we,
  input logic [LANES-1:0] mul_we,
  input logic [LANES-1:0] flag_a,
  input logic [LANES-1:0] flag_b,
  input logic             cond_err
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (add_we == '0) && (mul_we == '0) && !cond_err);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flag_a) && $stable(flag_b));

  assert_zero_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond == 7'd0) |-> (&add_we) && (&mul_we));

  assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond == 7'b0010000) |-> cond_err);

  assert_bad_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |=> $stable(flag_a) && $stable(flag_b));

  assert_push_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond[6:2] == 5'd0 && cond[1:0] != 2'd0) |=> flag_b == $past(flag_a));

  assert_pred_ifa_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond[6:2] == 5'b01000) |-> add_we == flag_a);

endmodule

bind lane_flag_cond lane_flag_cond_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .cond(cond),
  .add_we(add_we), .mul_we(mul_we), .flag_a(flag_a), .flag_b(flag_b),
  .cond_err(cond_err)
);

// File: tb/test_lane_flag_cond.sv
module test_lane_flag_cond;
  localparam int L = 16;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [6:0] cond = '0;
  logic [L-1:0] add_z = '0, add_n = '0, add_c = '0, mul_z = '0, mul_n = '0, mul_c = '0;
  logic [L-1:0] add_we, mul_we, flag_a, flag_b;
  logic cond_err;

  int checks = 0, errors = 0, cycles = 0;
  logic [L-1:0] m_a = '0, m_b = '0, e_a, e_b, e_awe, e_mwe;
  logic e_err;
  string t_aw, t_mw, t_err, t_fl;

  always #10 clk = ~clk;

  lane_flag_cond #(.LANES(L)) i_lane_flag_cond (
    .clk(clk), .rst_n(rst_n), .valid(valid), .cond(cond),
    .add_z(add_z), .add_n(add_n), .add_c(add_c),
    .mul_z(mul_z), .mul_n(mul_n), .mul_c(mul_c),
    .add_we(add_we), .mul_we(mul_we), .flag_a(flag_a), .flag_b(flag_b),
    .cond_err(cond_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic predict(input logic [6:0] c);
    int ap = -1, mp = -1, au = -1, mu = -1, apr = -1, mpr = -1;
    bit bad = 0;
    string cls;
    logic [L-1:0] sz, sn, sc;
    casez (c)
      7'b0000000: cls = "R3";
      7'b00000??: begin ap = c[1:0]; cls = "R4"; end
      7'b000????: begin au = c[3:0]; cls = "R4"; end
      7'b0010000: begin bad = 1; cls = "R11"; end
      7'b00100??: begin mp = c[1:0]; cls = "R4"; end
      7'b001????: begin mu = c[3:0]; cls = "R4"; end
      7'b010????: begin apr = c[3:2]; if (c[1:0] != 0) mp = c[1:0]; cls = "R5"; end
      7'b011????: begin mpr = c[3:2]; if (c[1:0] != 0) ap = c[1:0]; cls = "R5"; end
      7'b1??00??: begin mpr = c[5:4]; apr = c[1:0]; cls = "R6"; end
      default:    begin mpr = c[5:4]; au = c[3:0]; cls = "R6"; end
    endcase
    if (au > 12 || mu > 12) bad = 1;
    t_err = bad ? "R11" : cls;
    t_aw  = bad ? "R11" : (apr >= 0 ? "R9" : "R10");
    t_mw  = bad ? "R11" : (mpr >= 0 ? "R9" : "R10");
    t_fl  = bad ? "R11" : ((ap > 0 || mp > 0) ? "R7" : ((au > 0 || mu > 0) ? "R8" : cls));
    e_err = bad;
    if (mp > 0 || mu > 0) begin sz = mul_z; sn = mul_n; sc = mul_c; end
    else begin sz = add_z; sn = add_n; sc = add_c; end
    for (int i = 0; i < L; i++) begin
      bit pa, pm, tv;
      int p, u, kk;
      pa = (apr == 0) ? m_a[i] : (apr == 1) ? m_b[i] : (apr == 2) ? !m_a[i] : (apr == 3) ? !m_b[i] : 1'b1;
      pm = (mpr == 0) ? m_a[i] : (mpr == 1) ? m_b[i] : (mpr == 2) ? !m_a[i] : (mpr == 3) ? !m_b[i] : 1'b1;
      e_awe[i] = !bad && pa;
      e_mwe[i] = !bad && pm;
      e_a[i] = m_a[i];
      e_b[i] = m_b[i];
      p = (ap > 0) ? ap : mp;
      u = (au > 0) ? au : mu;
      if (!bad && p > 0) begin
        e_b[i] = m_a[i];
        e_a[i] = (p == 1) ? sz[i] : (p == 2) ? sn[i] : sc[i];
      end else if (!bad && u > 0) begin
        kk = u - 1;
        tv = (kk / 4 == 0) ? sz[i] : (kk / 4 == 1) ? sn[i] : sc[i];
        if (kk % 4 == 1 || kk % 4 == 2) tv = !tv;
        e_a[i] = (kk % 4 < 2) ? (m_a[i] && tv) : !(m_a[i] || tv);
      end
    end
  endtask

  task automatic run_one(input logic [6:0] c);
    cond = c; valid = 1'b1;
    add_z = L'($urandom); add_n = L'($urandom); add_c = L'($urandom);
    mul_z = L'($urandom); mul_n = L'($urandom); mul_c = L'($urandom);
    #1;
    predict(c);
    chk(t_aw, "add_we", 32'(add_we), 32'(e_awe));
    chk(t_mw, "mul_we", 32'(mul_we), 32'(e_mwe));
    chk(t_err, "cond_err", 32'(cond_err), 32'(e_err));
    @(negedge clk);
    chk(t_fl, "flags", {flag_b, flag_a}, {e_b, e_a});
    m_a = e_a; m_b = e_b;
  endtask

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "flag_a", 32'(flag_a), 32'd0);   // R1 reset state
    chk("R1", "flag_b", 32'(flag_b), 32'd0);
    chk("R1", "cond_err", 32'(cond_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after release", {flag_b, flag_a}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 128; c++) run_one(7'(c));
      for (int j = 0; j < 3; j++) begin   // R2 idle cycles between sweeps
        valid = 1'b0; cond = 7'($urandom);
        add_z = L'($urandom); mul_c = L'($urandom);
        #1;
        chk("R2", "add_we idle", 32'(add_we), 32'd0);
        chk("R2", "mul_we idle", 32'(mul_we), 32'd0);
        chk("R2", "cond_err idle", 32'(cond_err), 32'd0);
        @(negedge clk);
        chk("R2", "flags idle", {flag_b, flag_a}, {m_b, m_a});
      end
    end
    valid = 1'b0;
    summary();
  end
endmodule